// File: doc/BRIEF.md
# BT message framer and responder

This block sits on the management-controller side of a block-transfer host interface. Host software pushes a request frame into an inbound byte buffer and pulses a "request ready" strobe. The block then checks the frame: it must hold at least four bytes, and the first byte must equal the number of bytes that follow it. A frame that passes is either answered on the spot, when it is an interface-capability query, or passed on to a command backend as a byte stream. The stream holds the network-function byte, the command byte and the payload, and carries a numeric tag. The block keeps the host's sequence byte aside while the backend works.

When the backend returns a response carrying the expected tag, the block rebuilds a host-format reply frame in the outbound buffer. It puts the saved sequence byte back in place, and it substitutes a short error frame when the response would not fit. After any reply is placed it drops its busy flag, raises host attention and pulses a response-ready event for the interrupt logic. Host-side register logic reads the outbound buffer through a random-access read port, guided by the reported reply length.

Top module: `bt_msg_framer`

## Requirements
- R1: After reset, `bmc_busy`, `b2h_atn`, `rsp_evt` and `fwd_valid` are 0 and `out_len` is 0.
- R2: A `req_go` pulse seen while the block is idle sets `bmc_busy` on the next clock edge, whatever the frame contains.
- R3: A frame of fewer than 4 inbound bytes is ignored on `req_go`. Nothing is forwarded, no reply is made, `bmc_busy` stays 1, and the inbound byte count is kept, so bytes written afterwards extend the same frame.
- R4: If the first byte is not the inbound count minus 1, or more bytes were written than the inbound buffer holds, the frame is dropped on `req_go`. No reply is made and the inbound count returns to 0.
- R5: A frame whose byte 1 is 0x18 and byte 3 is 0x36 is answered locally with a 10-byte reply and is not forwarded. The reply bytes are: 9, byte1 OR 0x04, byte2, byte3, 0, 1, min(IN_DEPTH,255), min(OUT_DEPTH,255), 10, 0.
- R6: Any other valid frame is forwarded on the `fwd_*` stream as byte 1, then bytes 3 to count-1 in order. `fwd_last` marks the final byte, `fwd_tag` carries the expected tag, and data stay stable while `fwd_valid` is high and `fwd_ready` is low.
- R7: While a forwarded request waits for its response, further `req_go` pulses are ignored: nothing is forwarded and no reply is produced.
- R8: A backend response is accepted only if `bk_tag` on its first beat equals the expected tag. The expected tag starts at 0 and increments by 1 on each accepted response. A response with any other tag is discarded without a reply.
- R9: An accepted response r[0..n-1] with n <= OUT_DEPTH-2 produces an (n+2)-byte reply: n+1, r[0], saved sequence byte, then r[1..n-1]. `out_len` is n+2.
- R10: An accepted response with n > OUT_DEPTH-2 produces the 5-byte reply 4, r[0], saved sequence byte, r[1], 0xCA, and `out_len` is 5.
- R11: When a reply is complete, `bmc_busy` goes to 0, `b2h_atn` goes to 1 and `rsp_evt` is high for exactly one cycle. An `atn_clr` pulse returns `b2h_atn` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Append `host_wr_data` to the inbound frame |
| host_wr_data | input | 8 | Inbound byte from the host |
| host_wr_clr | input | 1 | Reset the inbound byte count to 0 |
| req_go | input | 1 | Request-ready strobe from the host |
| out_rd_addr | input | $clog2(OUT_DEPTH) | Outbound buffer read index |
| out_rd_data | output | 8 | Outbound byte at `out_rd_addr` |
| out_len | output | $clog2(OUT_DEPTH+1) | Length of the current reply in bytes |
| bmc_busy | output | 1 | Controller busy flag |
| b2h_atn | output | 1 | Reply-available attention flag |
| atn_clr | input | 1 | Host acknowledge, clears `b2h_atn` |
| rsp_evt | output | 1 | One-cycle reply-ready event to the interrupt logic |
| fwd_valid | output | 1 | Forwarded request byte valid |
| fwd_ready | input | 1 | Backend accepts the forwarded byte |
| fwd_data | output | 8 | Forwarded request byte |
| fwd_last | output | 1 | Final byte of the forwarded request |
| fwd_tag | output | TAG_W | Tag attached to the forwarded request |
| bk_valid | input | 1 | Backend response byte valid |
| bk_data | input | 8 | Backend response byte |
| bk_last | input | 1 | Final byte of the backend response |
| bk_tag | input | TAG_W | Tag of the backend response |

## Verification
The hardest states to reach are the ones where stray traffic arrives while a request is outstanding: a second request strobe, and a response with the wrong tag. The bench holds a request in the waiting state by not answering it. During that wait it writes a fresh capability query and strobes it, then sends a response with the wrong tag. Only after checking that neither produced activity does it send the correctly tagged response. Two more cases are checked through a later, well-formed request, because the inbound count cannot be seen at the ports: whether the count was kept after a short frame, and whether it was cleared after a bad or overrun frame.

// File: rtl/bt_fr_pkg.sv
package bt_fr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FWD  = 3'd1,
        ST_WAIT = 3'd2,
        ST_RSP  = 3'd3,
        ST_DROP = 3'd4,
        ST_FIN  = 3'd5,
        ST_CAP  = 3'd6
    } fr_state_e;

    localparam logic [7:0] NETFN_APP_REQ  = 8'h18;
    localparam logic [7:0] CMD_CAPS       = 8'h36;
    localparam logic [7:0] RSP_NETFN_BIT  = 8'h04;
    localparam logic [7:0] CC_TOO_LONG    = 8'hCA;
    localparam logic [7:0] CAP_MAX_REQS   = 8'd1;
    localparam logic [7:0] CAP_RSP_SECS   = 8'd10;
    localparam logic [7:0] CAP_RETRIES    = 8'd0;
    localparam int         MIN_FRAME      = 4;
    localparam int         CAP_LEN        = 10;

    function automatic logic [7:0] size_byte(input int unsigned depth);
        return (depth > 255) ? 8'hFF : 8'(depth);
    endfunction

endpackage

// File: rtl/bt_fr_inbuf.sv
module bt_fr_inbuf #(
    parameter int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [3:0][7:0]  hdr_o,
    input  logic [AW-1:0]    rd_idx_i,
    output logic [7:0]       rd_data_o
);

    localparam int CNT_MAX = DEPTH + 1;

    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             store;

    always_comb begin
        cnt_d = cnt_q;
        store = 1'b0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (wr_en_i) begin
            store = (int'(cnt_q) < DEPTH);
            if (int'(cnt_q) < CNT_MAX) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (store) begin
            mem[AW'(cnt_q)] <= wr_data_i;
        end
    end

    assign cnt_o     = cnt_q;
    assign rd_data_o = mem[rd_idx_i];

    for (genvar g = 0; g < 4; g++) begin : g_hdr
        assign hdr_o[g] = mem[g];
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= CNT_MAX); // R4

endmodule

// File: rtl/bt_fr_outbuf.sv
module bt_fr_outbuf #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/bt_fr_seq.sv
module bt_fr_seq
    import bt_fr_pkg::*;
#(
    parameter int IN_DEPTH  = 64,
    parameter int OUT_DEPTH = 64,
    parameter int TAG_W     = 8,
    localparam int IN_AW  = $clog2(IN_DEPTH),
    localparam int CNT_W  = $clog2(IN_DEPTH + 2),
    localparam int OUT_AW = $clog2(OUT_DEPTH),
    localparam int OLEN_W = $clog2(OUT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_go_i,
    input  logic              atn_clr_i,
    input  logic [CNT_W-1:0]  in_cnt_i,
    input  logic [3:0][7:0]   in_hdr_i,
    input  logic [7:0]        in_rd_data_i,
    output logic [IN_AW-1:0]  in_rd_idx_o,
    output logic              in_clr_o,
    output logic              out_we_o,
    output logic [OUT_AW-1:0] out_waddr_o,
    output logic [7:0]        out_wdata_o,
    output logic [OLEN_W-1:0] out_len_o,
    output logic              busy_o,
    output logic              atn_o,
    output logic              evt_o,
    output logic              fwd_valid_o,
    input  logic              fwd_ready_i,
    output logic [7:0]        fwd_data_o,
    output logic              fwd_last_o,
    output logic [TAG_W-1:0]  fwd_tag_o,
    input  logic              bk_valid_i,
    input  logic [7:0]        bk_data_i,
    input  logic              bk_last_i,
    input  logic [TAG_W-1:0]  bk_tag_i
);

    localparam int         RL_W     = $clog2(OUT_DEPTH);
    localparam int         RL_MAX   = OUT_DEPTH - 1;
    localparam int         FIT_MAX  = OUT_DEPTH - 2;
    localparam logic [7:0] IN_SIZE  = size_byte(IN_DEPTH);
    localparam logic [7:0] OUT_SIZE = size_byte(OUT_DEPTH);

    typedef struct packed {
        fr_state_e         st;
        logic [7:0]        seq;
        logic [7:0]        netfn;
        logic [7:0]        cmd;
        logic [IN_AW-1:0]  idx;
        logic [RL_W-1:0]   rlen;
        logic [3:0]        step;
        logic [TAG_W-1:0]  tag;
        logic              busy;
        logic              atn;
        logic              evt;
        logic [OLEN_W-1:0] olen;
    } ctx_t;

    ctx_t              d, q;
    logic              done;
    logic [OLEN_W-1:0] done_len;
    logic              too_long;
    logic              last_fwd;
    logic [7:0]        cap_byte;

    assign too_long = (int'(q.rlen) > FIT_MAX);
    assign last_fwd = (int'(q.idx) == int'(in_cnt_i) - 1);

    always_comb begin
        case (q.step)
            4'd0:    cap_byte = 8'(CAP_LEN - 1);
            4'd1:    cap_byte = q.netfn | RSP_NETFN_BIT;
            4'd2:    cap_byte = q.seq;
            4'd3:    cap_byte = q.cmd;
            4'd4:    cap_byte = 8'h00;
            4'd5:    cap_byte = CAP_MAX_REQS;
            4'd6:    cap_byte = IN_SIZE;
            4'd7:    cap_byte = OUT_SIZE;
            4'd8:    cap_byte = CAP_RSP_SECS;
            default: cap_byte = CAP_RETRIES;
        endcase
    end

    always_comb begin
        d           = q;
        d.evt       = 1'b0;
        in_clr_o    = 1'b0;
        out_we_o    = 1'b0;
        out_waddr_o = '0;
        out_wdata_o = '0;
        done        = 1'b0;
        done_len    = '0;

        if (atn_clr_i) begin
            d.atn = 1'b0;
        end

        case (q.st)
            ST_IDLE: begin
                if (req_go_i) begin
                    d.busy = 1'b1;
                    if (int'(in_cnt_i) >= MIN_FRAME) begin
                        if ((int'(in_cnt_i) > IN_DEPTH) ||
                            (int'(in_hdr_i[0]) != int'(in_cnt_i) - 1)) begin
                            in_clr_o = 1'b1;
                        end else begin
                            d.seq   = in_hdr_i[2];
                            d.netfn = in_hdr_i[1];
                            d.cmd   = in_hdr_i[3];
                            d.step  = '0;
                            if (in_hdr_i[1] == NETFN_APP_REQ && in_hdr_i[3] == CMD_CAPS) begin
                                d.st = ST_CAP;
                            end else begin
                                d.st  = ST_FWD;
                                d.idx = IN_AW'(1);
                            end
                        end
                    end
                end
            end

            ST_FWD: begin
                if (fwd_ready_i) begin
                    if (last_fwd) begin
                        d.st = ST_WAIT;
                    end else if (q.idx == IN_AW'(1)) begin
                        d.idx = IN_AW'(3);
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end

            ST_WAIT: begin
                if (bk_valid_i) begin
                    if (bk_tag_i == q.tag) begin
                        d.tag       = q.tag + 1'b1;
                        d.netfn     = bk_data_i;
                        d.rlen      = RL_W'(1);
                        d.step      = '0;
                        out_we_o    = 1'b1;
                        out_waddr_o = OUT_AW'(1);
                        out_wdata_o = bk_data_i;
                        d.st        = bk_last_i ? ST_FIN : ST_RSP;
                    end else if (!bk_last_i) begin
                        d.st = ST_DROP;
                    end
                end
            end

            ST_RSP: begin
                if (bk_valid_i) begin
                    if (q.rlen == RL_W'(1)) begin
                        d.cmd = bk_data_i;
                    end
                    if (int'(q.rlen) + 2 < OUT_DEPTH) begin
                        out_we_o    = 1'b1;
                        out_waddr_o = OUT_AW'(int'(q.rlen) + 2);
                        out_wdata_o = bk_data_i;
                    end
                    if (int'(q.rlen) < RL_MAX) begin
                        d.rlen = q.rlen + 1'b1;
                    end
                    if (bk_last_i) begin
                        d.st   = ST_FIN;
                        d.step = '0;
                    end
                end
            end

            ST_DROP: begin
                if (bk_valid_i && bk_last_i) begin
                    d.st = ST_WAIT;
                end
            end

            ST_FIN: begin
                d.step = q.step + 4'd1;
                case (q.step)
                    4'd0: begin
                        out_we_o    = 1'b1;
                        out_waddr_o = '0;
                        out_wdata_o = too_long ? 8'd4 : 8'(int'(q.rlen) + 1);
                    end
                    4'd1: begin
                        out_we_o    = 1'b1;
                        out_waddr_o = OUT_AW'(2);
                        out_wdata_o = q.seq;
                    end
                    default: begin
                        if (too_long) begin
                            out_we_o    = 1'b1;
                            out_waddr_o = OUT_AW'(4);
                            out_wdata_o = CC_TOO_LONG;
                        end
                        done     = 1'b1;
                        done_len = too_long ? OLEN_W'(5) : OLEN_W'(int'(q.rlen) + 2);
                    end
                endcase
            end

            ST_CAP: begin
                out_we_o    = 1'b1;
                out_waddr_o = OUT_AW'(q.step);
                out_wdata_o = cap_byte;
                d.step      = q.step + 4'd1;
                if (int'(q.step) == CAP_LEN - 1) begin
                    done     = 1'b1;
                    done_len = OLEN_W'(CAP_LEN);
                end
            end

            default: d.st = ST_IDLE;
        endcase

        if (done) begin
            d.st   = ST_IDLE;
            d.busy = 1'b0;
            d.atn  = 1'b1;
            d.evt  = 1'b1;
            d.olen = done_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_rd_idx_o = q.idx;
    assign fwd_valid_o = (q.st == ST_FWD);
    assign fwd_data_o  = in_rd_data_i;
    assign fwd_last_o  = (q.st == ST_FWD) && last_fwd;
    assign fwd_tag_o   = q.tag;
    assign out_len_o   = q.olen;
    assign busy_o      = q.busy;
    assign atn_o       = q.atn;
    assign evt_o       = q.evt;

    AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_go_i && q.st == ST_IDLE) |=> busy_o); // R2
    AST_FWD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_o && !fwd_ready_i) |=> (fwd_valid_o && $stable(fwd_data_o))); // R6
    AST_NO_FWD_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT) |=> !fwd_valid_o); // R7
    AST_TAG_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.tag) |-> (q.tag == $past(q.tag) + 1'b1)); // R8
    AST_OUT_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        int'(out_len_o) <= OUT_DEPTH); // R9
    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o); // R11
    AST_EVT_FREES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (!busy_o && atn_o)); // R11

endmodule

// File: rtl/bt_msg_framer.sv
module bt_msg_framer #(
    parameter int IN_DEPTH  = 64,
    parameter int OUT_DEPTH = 64,
    parameter int TAG_W     = 8,
    localparam int IN_AW  = $clog2(IN_DEPTH),
    localparam int CNT_W  = $clog2(IN_DEPTH + 2),
    localparam int OUT_AW = $clog2(OUT_DEPTH),
    localparam int OLEN_W = $clog2(OUT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [7:0]        host_wr_data,
    input  logic              host_wr_clr,
    input  logic              req_go,
    input  logic [OUT_AW-1:0] out_rd_addr,
    output logic [7:0]        out_rd_data,
    output logic [OLEN_W-1:0] out_len,
    output logic              bmc_busy,
    output logic              b2h_atn,
    input  logic              atn_clr,
    output logic              rsp_evt,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [7:0]        fwd_data,
    output logic              fwd_last,
    output logic [TAG_W-1:0]  fwd_tag,
    input  logic              bk_valid,
    input  logic [7:0]        bk_data,
    input  logic              bk_last,
    input  logic [TAG_W-1:0]  bk_tag
);

    logic [CNT_W-1:0]  in_cnt;
    logic [3:0][7:0]   in_hdr;
    logic [IN_AW-1:0]  in_rd_idx;
    logic [7:0]        in_rd_data;
    logic              seq_clr;
    logic              ob_we;
    logic [OUT_AW-1:0] ob_waddr;
    logic [7:0]        ob_wdata;

    bt_fr_inbuf #(.DEPTH(IN_DEPTH)) u_inbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (host_wr_en),
        .wr_data_i (host_wr_data),
        .clr_i     (host_wr_clr | seq_clr),
        .cnt_o     (in_cnt),
        .hdr_o     (in_hdr),
        .rd_idx_i  (in_rd_idx),
        .rd_data_o (in_rd_data)
    );

    bt_fr_outbuf #(.DEPTH(OUT_DEPTH)) u_outbuf (
        .clk     (clk),
        .we_i    (ob_we),
        .waddr_i (ob_waddr),
        .wdata_i (ob_wdata),
        .raddr_i (out_rd_addr),
        .rdata_o (out_rd_data)
    );

    bt_fr_seq #(
        .IN_DEPTH  (IN_DEPTH),
        .OUT_DEPTH (OUT_DEPTH),
        .TAG_W     (TAG_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_go_i     (req_go),
        .atn_clr_i    (atn_clr),
        .in_cnt_i     (in_cnt),
        .in_hdr_i     (in_hdr),
        .in_rd_data_i (in_rd_data),
        .in_rd_idx_o  (in_rd_idx),
        .in_clr_o     (seq_clr),
        .out_we_o     (ob_we),
        .out_waddr_o  (ob_waddr),
        .out_wdata_o  (ob_wdata),
        .out_len_o    (out_len),
        .busy_o       (bmc_busy),
        .atn_o        (b2h_atn),
        .evt_o        (rsp_evt),
        .fwd_valid_o  (fwd_valid),
        .fwd_ready_i  (fwd_ready),
        .fwd_data_o   (fwd_data),
        .fwd_last_o   (fwd_last),
        .fwd_tag_o    (fwd_tag),
        .bk_valid_i   (bk_valid),
        .bk_data_i    (bk_data),
        .bk_last_i    (bk_last),
        .bk_tag_i     (bk_tag)
    );

endmodule

// File: tb/test_bt_msg_framer.sv
module test_bt_msg_framer;

    localparam int CLK_PERIOD = 10;
    localparam int IN_D  = 16;
    localparam int OUT_D = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_wr_data = '0;
    logic       host_wr_clr = 1'b0;
    logic       req_go = 1'b0;
    logic [3:0] out_rd_addr = '0;
    logic [7:0] out_rd_data;
    logic [4:0] out_len;
    logic       bmc_busy, b2h_atn, rsp_evt;
    logic       atn_clr = 1'b0;
    logic       fwd_valid, fwd_last;
    logic       fwd_ready = 1'b1;
    logic [7:0] fwd_data;
    logic [7:0] fwd_tag;
    logic       bk_valid = 1'b0;
    logic [7:0] bk_data = '0;
    logic       bk_last = 1'b0;
    logic [7:0] bk_tag = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] msg  [32];
    logic [7:0] rsp  [32];
    logic [7:0] fexp [32];
    logic [7:0] oexp [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    bt_msg_framer #(.IN_DEPTH(IN_D), .OUT_DEPTH(OUT_D), .TAG_W(8)) i_bt_msg_framer (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_wr_clr(host_wr_clr),
        .req_go(req_go), .out_rd_addr(out_rd_addr), .out_rd_data(out_rd_data),
        .out_len(out_len), .bmc_busy(bmc_busy), .b2h_atn(b2h_atn), .atn_clr(atn_clr),
        .rsp_evt(rsp_evt), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
        .fwd_data(fwd_data), .fwd_last(fwd_last), .fwd_tag(fwd_tag),
        .bk_valid(bk_valid), .bk_data(bk_data), .bk_last(bk_last), .bk_tag(bk_tag)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        host_wr_en = 1'b1; host_wr_data = b; tick(); host_wr_en = 1'b0;
    endtask

    task automatic clr_in();
        host_wr_clr = 1'b1; tick(); host_wr_clr = 1'b0;
    endtask

    task automatic go();
        req_go = 1'b1; tick(); req_go = 1'b0;
    endtask

    task automatic put_frame(input int first, input int n);
        for (int i = first; i < n; i++) wr(msg[i]);
    endtask

    task automatic collect_fwd(input int n, input int tag, input string req);
        int k = 0;
        bit seen_last = 0;
        fwd_ready = 1'b1;
        for (int c = 0; c < 24 && !seen_last; c++) begin
            if (fwd_valid && k < 32) begin
                chk(fwd_data == fexp[k], req, "forward byte", int'(fwd_data), int'(fexp[k]));
                chk(fwd_last == (k == n - 1), req, "forward last", int'(fwd_last), int'(k == n - 1));
                chk(fwd_tag == 8'(tag), req, "forward tag", int'(fwd_tag), tag);
                if (fwd_last) seen_last = 1;
                k++;
            end
            tick();
        end
        chk(k == n, req, "forward byte count", k, n);
    endtask

    task automatic send_rsp(input int tag, input int n);
        for (int i = 0; i < n; i++) begin
            bk_valid = 1'b1; bk_data = rsp[i]; bk_last = (i == n - 1); bk_tag = 8'(tag);
            tick();
        end
        bk_valid = 1'b0; bk_last = 1'b0;
    endtask

    task automatic quiet(input int cycles, input string req);
        bit busy_seen = 0;
        for (int c = 0; c < cycles; c++) begin
            if (fwd_valid || rsp_evt) busy_seen = 1;
            tick();
        end
        chk(!busy_seen, req, "no forward and no reply", int'(busy_seen), 0);
    endtask

    task automatic expect_reply(input int n, input string req);
        for (int c = 0; c < 40 && !rsp_evt; c++) tick();
        chk(rsp_evt == 1'b1, "R11", "reply event", int'(rsp_evt), 1);
        chk(bmc_busy == 1'b0, "R11", "busy cleared", int'(bmc_busy), 0);
        chk(b2h_atn == 1'b1, "R11", "attention set", int'(b2h_atn), 1);
        chk(int'(out_len) == n, req, "reply length", int'(out_len), n);
        for (int i = 0; i < n; i++) begin
            out_rd_addr = 4'(i);
            #1;
            chk(out_rd_data == oexp[i], req, $sformatf("reply byte %0d", i), int'(out_rd_data), int'(oexp[i]));
        end
        tick();
        chk(rsp_evt == 1'b0, "R11", "event lasts one cycle", int'(rsp_evt), 0);
    endtask

    function automatic int build_normal(input int n, input logic [7:0] seq);
        oexp[0] = 8'(n + 1);
        oexp[1] = rsp[0];
        oexp[2] = seq;
        for (int i = 1; i < n; i++) oexp[i + 2] = rsp[i];
        return n + 2;
    endfunction

    task automatic t_reset();
        chk(bmc_busy == 0, "R1", "busy after reset", int'(bmc_busy), 0);
        chk(b2h_atn == 0, "R1", "atn after reset", int'(b2h_atn), 0);
        chk(rsp_evt == 0, "R1", "event after reset", int'(rsp_evt), 0);
        chk(fwd_valid == 0, "R1", "forward valid after reset", int'(fwd_valid), 0);
        chk(out_len == 0, "R1", "out_len after reset", int'(out_len), 0);
    endtask

    task automatic t_caps();
        msg[0] = 8'd3; msg[1] = 8'h18; msg[2] = 8'h21; msg[3] = 8'h36;
        clr_in(); put_frame(0, 4); go();
        chk(bmc_busy == 1, "R2", "busy after strobe", int'(bmc_busy), 1);
        chk(fwd_valid == 0, "R5", "capability not forwarded", int'(fwd_valid), 0);
        oexp[0] = 8'd9;  oexp[1] = 8'h1C; oexp[2] = 8'h21; oexp[3] = 8'h36; oexp[4] = 8'd0;
        oexp[5] = 8'd1;  oexp[6] = 8'd16; oexp[7] = 8'd16; oexp[8] = 8'd10; oexp[9] = 8'd0;
        expect_reply(10, "R5");
        atn_clr = 1'b1; tick(); atn_clr = 1'b0;
        chk(b2h_atn == 0, "R11", "attention cleared by host", int'(b2h_atn), 0);
    endtask

    task automatic t_forward();
        logic [7:0] d0;
        msg[0] = 8'd5; msg[1] = 8'h28; msg[2] = 8'h44; msg[3] = 8'h01; msg[4] = 8'hAA; msg[5] = 8'hBB;
        fexp[0] = 8'h28; fexp[1] = 8'h01; fexp[2] = 8'hAA; fexp[3] = 8'hBB;
        clr_in(); put_frame(0, 6);
        fwd_ready = 1'b0;
        go();
        d0 = fwd_data;
        chk(fwd_valid == 1, "R6", "forward valid", int'(fwd_valid), 1);
        tick(); tick();
        chk(fwd_valid == 1 && fwd_data == d0, "R6", "held under backpressure", int'(fwd_data), int'(d0));
        collect_fwd(4, 0, "R6");
        rsp[0] = 8'h2C; rsp[1] = 8'h01; rsp[2] = 8'h00; rsp[3] = 8'h55;
        send_rsp(0, 4);
        expect_reply(build_normal(4, 8'h44), "R9");
    endtask

    task automatic t_outstanding();
        msg[0] = 8'd4; msg[1] = 8'h30; msg[2] = 8'h07; msg[3] = 8'h02; msg[4] = 8'h99;
        fexp[0] = 8'h30; fexp[1] = 8'h02; fexp[2] = 8'h99;
        clr_in(); put_frame(0, 5); go();
        collect_fwd(3, 1, "R8");
        msg[0] = 8'd3; msg[1] = 8'h18; msg[2] = 8'h22; msg[3] = 8'h36;
        clr_in(); put_frame(0, 4); go();
        quiet(12, "R7");
        rsp[0] = 8'h34; rsp[1] = 8'h02; rsp[2] = 8'h00;
        send_rsp(5, 3);
        quiet(12, "R8");
        chk(bmc_busy == 1, "R8", "still busy after wrong tag", int'(bmc_busy), 1);
        send_rsp(1, 3);
        expect_reply(build_normal(3, 8'h07), "R8");
    endtask

    task automatic t_sizes();
        msg[0] = 8'd3; msg[1] = 8'h30; msg[2] = 8'h10; msg[3] = 8'h05;
        fexp[0] = 8'h30; fexp[1] = 8'h05;
        clr_in(); put_frame(0, 4); go();
        collect_fwd(2, 2, "R9");
        rsp[0] = 8'h34; rsp[1] = 8'h05; rsp[2] = 8'h00;
        for (int i = 3; i < 15; i++) rsp[i] = 8'(i);
        send_rsp(2, 14);
        expect_reply(build_normal(14, 8'h10), "R9");
        msg[2] = 8'h11;
        clr_in(); put_frame(0, 4); go();
        collect_fwd(2, 3, "R10");
        send_rsp(3, 15);
        oexp[0] = 8'd4; oexp[1] = 8'h34; oexp[2] = 8'h11; oexp[3] = 8'h05; oexp[4] = 8'hCA;
        expect_reply(5, "R10");
    endtask

    task automatic t_short();
        msg[0] = 8'd4; msg[1] = 8'h30; msg[2] = 8'h0B; msg[3] = 8'h06; msg[4] = 8'h77;
        fexp[0] = 8'h30; fexp[1] = 8'h06; fexp[2] = 8'h77;
        chk(bmc_busy == 0, "R2", "idle before strobe", int'(bmc_busy), 0);
        clr_in(); put_frame(0, 3); go();
        chk(bmc_busy == 1, "R2", "busy on short frame", int'(bmc_busy), 1);
        quiet(8, "R3");
        chk(bmc_busy == 1, "R3", "busy kept on short frame", int'(bmc_busy), 1);
        put_frame(3, 5); go();
        collect_fwd(3, 4, "R3");
        rsp[0] = 8'h34; rsp[1] = 8'h06; rsp[2] = 8'h00;
        send_rsp(4, 3);
        expect_reply(build_normal(3, 8'h0B), "R3");
    endtask

    task automatic t_bad_len();
        msg[0] = 8'd7; msg[1] = 8'h30; msg[2] = 8'h0C; msg[3] = 8'h06;
        clr_in(); put_frame(0, 4); go();
        quiet(8, "R4");
        msg[0] = 8'd3; msg[1] = 8'h30; msg[2] = 8'h0D; msg[3] = 8'h08;
        fexp[0] = 8'h30; fexp[1] = 8'h08;
        put_frame(0, 4); go();
        collect_fwd(2, 5, "R4");
        rsp[0] = 8'h34; rsp[1] = 8'h08;
        send_rsp(5, 2);
        expect_reply(build_normal(2, 8'h0D), "R4");
        clr_in();
        wr(8'd16);
        for (int i = 1; i < 17; i++) wr(8'(i));
        go();
        quiet(8, "R4");
        msg[2] = 8'h0E; msg[3] = 8'h09; fexp[1] = 8'h09;
        put_frame(0, 4); go();
        collect_fwd(2, 6, "R4");
        rsp[1] = 8'h09;
        send_rsp(6, 2);
        expect_reply(build_normal(2, 8'h0E), "R4");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_caps();
        t_forward();
        t_outstanding();
        t_sizes();
        t_short();
        t_bad_len();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog: actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule